// File: doc/BRIEF.md
# Multiplier-Free Four-Tap FIR Filter

This block computes a four-tap finite impulse response filter without any multiplier. Every accepted input sample is pushed into a four-deep history. The four stored samples are then walked through one bit position per clock, least-significant bit first. At each step the bits of equal weight from all four taps form a 4-bit index into a 16-entry table. Entry `a` of that table holds the sum of the coefficients whose index bit is set. A shift-and-add accumulator weights each table word by the significance of its bit position. On the sign-bit step it subtracts the word instead of adding it, so that two's complement samples come out right.

Samples enter over a valid/ready handshake. The filter takes one sample, computes for `W` cycles, and then pulses `out_valid` with the full-precision result. While it computes, `in_ready` is low, and any sample offered in that time is neither taken nor stored. The output side has no back-pressure. The result is a registered value that stays constant until the next pulse, so a consumer that needs it later can read it at any time before then. The table is built from the four coefficient parameters at elaboration.

Top module: `da_fir4`

## Requirements
- R1: `in_ready` is high whenever the filter is idle. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after that edge until the cycle in which `out_valid` is high, and it is high again in that cycle.
- R2: `out_valid` is high for exactly one cycle. That cycle follows the `W`-th rising edge after the edge that took the sample.
- R3: With `x0` the newest taken sample and `x3` the oldest of the last four, the result is exactly `C0*x0 + C1*x1 + C2*x2 + C3*x3`. It is signed and `W+CW+2` bits wide.
- R4: Samples and coefficients are two's complement. The most negative sample value gives the exact product.
- R5: A sample offered while `in_ready` is low has no effect. It does not enter the history and does not change any later result.
- R6: `out_result` holds its value in every cycle in which `out_valid` is low.
- R7: After reset the history is all zero, `in_ready` is 1, `out_valid` is 0 and `out_result` is 0.
- R8: No coefficient or sample combination at the limits of their ranges overflows the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Filter idle and able to take a sample |
| in_sample | input | W | Two's complement input sample |
| out_valid | output | 1 | One-cycle pulse: result is new |
| out_result | output | W+CW+2 | Filtered result, held between pulses |

## Verification
The sample is taken at edge n, and `out_valid` with its result is due after edge n+W. `in_ready` falls after edge n and rises again after edge n+W. A behavioural model in the bench advances on the same edges: it counts cycles since the sample was taken and recomputes the sum of products from a queue of past samples. Every output is compared with that model at the falling edge, so each result is checked in exactly the cycle it is due. Junk samples are offered during every busy window, and the results after them show whether any of them leaked into the history.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } da_state_e;

  // Sum of the coefficients selected by the four index bits.
  function automatic int subset_sum(input int idx, input int k0, input int k1,
                                    input int k2, input int k3);
    int s;
    s = 0;
    if (idx[0]) s = s + k0;
    if (idx[1]) s = s + k1;
    if (idx[2]) s = s + k2;
    if (idx[3]) s = s + k3;
    return s;
  endfunction

endpackage

// File: rtl/da_tap_line.sv
module da_tap_line #(
  parameter int W    = 8,
  parameter int NTAP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [W-1:0]    sample,
  output logic [NTAP-1:0] bits
);

  logic [W-1:0] hist [NTAP];
  logic [W-1:0] sreg [NTAP];

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    logic [W-1:0] fresh;
    if (i == 0) begin : g_head
      assign fresh = sample;
    end else begin : g_body
      assign fresh = hist[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist[i] <= '0;
        sreg[i] <= '0;
      end else if (load) begin
        hist[i] <= fresh;
        sreg[i] <= fresh;
      end else if (shift) begin
        sreg[i] <= {1'b0, sreg[i][W-1:1]};
      end
    end

    assign bits[i] = sreg[i][0];
  end

endmodule

// File: rtl/da_rom.sv
module da_rom
  import da_fir_pkg::*;
#(
  parameter int TW = 10,
  parameter int C0 = 1,
  parameter int C1 = 1,
  parameter int C2 = 1,
  parameter int C3 = 1
) (
  input  logic [3:0]           addr,
  output logic signed [TW-1:0] word
);

  logic signed [TW-1:0] lut [16];

  for (genvar a = 0; a < 16; a++) begin : g_entry
    localparam int ENTRY = subset_sum(a, C0, C1, C2, C3);
    assign lut[a] = TW'(ENTRY);
  end

  assign word = lut[addr];

endmodule

// File: rtl/da_scale_acc.sv
module da_scale_acc #(
  parameter int W  = 8,
  parameter int TW = 10,
  localparam int UW = TW + 1,
  localparam int RW = UW + W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic                 subtract,
  input  logic signed [TW-1:0] word,
  output logic [RW-1:0]        acc,
  output logic [RW-1:0]        acc_next
);

  logic signed [UW-1:0] upper;
  logic signed [UW-1:0] ext;
  logic signed [UW-1:0] sum;

  always_comb begin
    upper    = acc[RW-1:W];
    ext      = {word[TW-1], word};
    sum      = subtract ? (upper - ext) : (upper + ext);
    acc_next = {sum[UW-1], sum, acc[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc <= '0;
    end else if (step) begin
      acc <= acc_next;
    end
  end

endmodule

// File: rtl/da_ctrl.sv
module da_ctrl
  import da_fir_pkg::*;
#(
  parameter int W = 8,
  localparam int CNTW = (W > 1) ? $clog2(W) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic last,
  output logic done
);

  da_state_e       state;
  logic [CNTW-1:0] cnt;

  assign in_ready = (state == ST_IDLE);
  assign load     = in_ready && in_valid;
  assign step     = (state == ST_RUN);
  assign last     = step && (cnt == CNTW'(W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        state <= ST_RUN;
        cnt   <= '0;
      end else if (last) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/da_fir4.sv
module da_fir4 #(
  parameter int W  = 8,
  parameter int CW = 8,
  parameter int C0 = -128,
  parameter int C1 = 127,
  parameter int C2 = -37,
  parameter int C3 = 90,
  localparam int OW = W + CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_sample,
  output logic          out_valid,
  output logic [OW-1:0] out_result
);

  localparam int NTAP = 4;
  localparam int TW   = CW + 2;
  localparam int RW   = TW + 1 + W;

  logic                 load, step, last, done;
  logic [NTAP-1:0]      tap_bits;
  logic signed [TW-1:0] word;
  logic [RW-1:0]        acc, acc_next;

  da_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .step(step), .last(last), .done(done)
  );

  da_tap_line #(.W(W), .NTAP(NTAP)) u_taps (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(step),
    .sample(in_sample), .bits(tap_bits)
  );

  da_rom #(.TW(TW), .C0(C0), .C1(C1), .C2(C2), .C3(C3)) u_rom (
    .addr(tap_bits), .word(word)
  );

  da_scale_acc #(.W(W), .TW(TW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(load), .step(step),
    .subtract(last), .word(word), .acc(acc), .acc_next(acc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_result <= '0;
    end else if (last) begin
      out_result <= acc_next[OW-1:0];
    end
  end

  assign out_valid = done;

endmodule

// File: rtl/da_fir4_chk.sv
module da_fir4_chk #(
  parameter int W  = 8,
  parameter int OW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [OW-1:0] out_result
);

  int since;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= 0;
      armed <= 1'b0;
    end else if (in_valid && in_ready) begin
      since <= 0;
      armed <= 1'b1;
    end else if (armed && since <= W) begin
      since <= since + 1;
    end
  end

  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_ready_with_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (armed && since == W));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(rst_n)) |-> $stable(out_result));

endmodule

bind da_fir4 da_fir4_chk #(.W(W), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/da_fir4_tb.sv
module da_fir4_tb;

  localparam int W  = 8;
  localparam int CW = 8;
  localparam int K0 = -128;
  localparam int K1 = 127;
  localparam int K2 = -37;
  localparam int K3 = 90;
  localparam int OW = W + CW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_sample = '0;
  logic          in_ready;
  logic          out_valid;
  logic [OW-1:0] out_result;

  int errors = 0;
  int checks = 0;
  string tag = "R3";

  always #10 clk = ~clk;

  da_fir4 #(.W(W), .CW(CW), .C0(K0), .C1(K1), .C2(K2), .C3(K3)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_result(out_result)
  );

  // Behavioural reference model, advanced on every rising edge.
  int hist[$] = '{0, 0, 0, 0};
  bit m_ready = 1'b1;
  bit m_valid = 1'b0;
  int m_result = 0;
  int m_pend = 0;
  int m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0, 0};
      m_ready = 1'b1; m_valid = 1'b0; m_result = 0; m_cnt = 0;
    end else begin
      m_valid = 1'b0;
      if (m_ready && in_valid) begin
        hist.push_front(int'($signed(in_sample)));
        void'(hist.pop_back());
        m_pend = K0*hist[0] + K1*hist[1] + K2*hist[2] + K3*hist[3];
        m_ready = 1'b0;
        m_cnt = 0;
      end else if (!m_ready) begin
        m_cnt++;
        if (m_cnt == W) begin
          m_ready = 1'b1; m_valid = 1'b1; m_result = m_pend;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (in_ready !== m_ready) begin
        errors++;
        $display("FAIL R1 in_ready got %0b expected %0b", in_ready, m_ready);
      end
      checks++;
      if (out_valid !== m_valid) begin
        errors++;
        $display("FAIL R2 out_valid got %0b expected %0b", out_valid, m_valid);
      end
      checks++;
      if (int'($signed(out_result)) != m_result) begin
        errors++;
        $display("FAIL %s out_result got %0d expected %0d",
                 m_valid ? tag : "R6", $signed(out_result), m_result);
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Offer v once ready; while busy, offer junk if junk is set (R5).
  task automatic send(input int v, input bit junk);
    @(negedge clk);
    while (!in_ready) begin
      in_valid  = junk;
      in_sample = W'(v ^ 8'h5A ^ cycles);
      @(negedge clk);
    end
    in_valid  = 1'b1;
    in_sample = W'(v);
    @(negedge clk);
    in_valid  = junk;
    in_sample = W'(~v);
  endtask

  int seed = 12345;

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state visible at the ports.
    checks++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0 || out_result !== '0) begin
      errors++;
      $display("FAIL R7 reset got ready=%0b valid=%0b res=%0d expected 1 0 0",
               in_ready, out_valid, out_result);
    end
    rst_n = 1'b1;

    // R3: impulse brings out each coefficient in turn.
    tag = "R3";
    send(1, 1'b0); send(0, 1'b0); send(0, 1'b0); send(0, 1'b0); send(0, 1'b0);
    // R4: most negative and most positive samples.
    tag = "R4";
    send(-128, 1'b0); send(-128, 1'b0); send(127, 1'b0); send(-1, 1'b0);
    // R8: extremes that push the sum to its largest magnitudes.
    tag = "R8";
    send(-128, 1'b0); send(127, 1'b0); send(-128, 1'b0); send(127, 1'b0);
    send(127, 1'b0); send(-128, 1'b0); send(127, 1'b0); send(-128, 1'b0);
    // R5: junk offered throughout every busy window.
    tag = "R5";
    for (int i = 0; i < 40; i++) begin
      seed = seed * 1103515245 + 12345;
      send((seed >>> 16) % 256, 1'b1);
    end
    // R1: in_valid held high, back-to-back takes on the done cycle.
    tag = "R3";
    in_valid = 1'b1;
    for (int i = 0; i < 6 * (W + 1); i++) begin
      in_sample = W'(i * 37 + 5);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (W + 4) @(negedge clk);

    // R7: reset mid-run clears the history.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R7";
    send(3, 1'b0);
    repeat (W + 3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule